// File: doc/BRIEF.md
# Daisy-Chainable Serial Switch Register

This block holds the on/off state of a bank of switch enables and is loaded over a three-wire serial link made of a frame strobe (`sync_n`, active low), a serial clock (`sclk`) and a data line (`din`). While the strobe is low, each falling clock edge moves one data bit into a shift register, most significant bit first. When the strobe returns high, the shift register is copied into a holding register that drives the enable outputs. Outputs therefore never change in the middle of a frame. A frame may carry any number of bits, and only the last eight shifted in take effect.

A serial output (`dout`) presents the bit leaving the top of the shift register. It changes on the rising serial clock edge, so a downstream unit wired to it can sample it on the next falling edge. Several units that share the strobe and clock, each chained output to input, load from one long frame and update on the same strobe edge. Between frames the serial output shows the register's top bit. This lets a downstream unit receive the upstream unit's old contents in their original order.

The serial lines are sampled by the block's own clock `clk` through synchronizer stages. The serial clock must therefore be several times slower than `clk`. An active-low reset clears everything asynchronously and is released in step with `clk`.

Top module: `serial_switch_reg`

## Requirements
- R1: While `sync_n` is low, each falling edge of `sclk` shifts the current `din` value into bit 0 of the shift register, and the older bits move one place toward the MSB.
- R2: `dout` changes only on a rising edge of `sclk` during a frame, and then shows the register MSB. A bit entered on `din` therefore reaches `dout` eight serial clocks later.
- R3: A frame of any length, including 5 and 11 bits, leaves the register holding the last eight bits shifted in. Bits beyond the last eight are older contents pushed out of the top.
- R4: `sw_en` changes only when `sync_n` rises, and it then takes the register contents. It stays stable throughout shifting.
- R5: While `sync_n` is high, toggling `sclk` or `din` leaves the shift register unchanged.
- R6: The first bit sent is the MSB. Register bit k drives `sw_en[k]`: bit 7 enables switch 8 and bit 0 enables switch 1. A 1 turns the switch on and a 0 turns it off.
- R7: `rst_n` low clears the shift register, `sw_en` and `dout` to zero at once, even in the middle of a frame. They stay zero until a frame completes.
- R8: Two units that share `sync_n` and `sclk`, with the first unit's `dout` wired to the second unit's `din`, both load from one frame. The second unit receives the first unit's previous register contents, and both update on the same `sync_n` rise.
- R9: While `sync_n` is high, `dout` shows the register MSB.
- R10: A frame in which `sync_n` falls and rises with no `sclk` edge copies the unchanged register to `sw_en`, so the switch states stay the same.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n | input | 1 | Frame strobe, low while shifting |
| sclk | input | 1 | Serial clock; shift on fall, chain output on rise |
| din | input | 1 | Serial data in, MSB first |
| sw_en | output | WIDTH (8) | Switch enables, 1 = on |
| dout | output | 1 | Chain output to the next unit's data input |

## Verification
A corrupted shift register is invisible on `sw_en` until the end of the frame, but it appears on `dout` one rising serial clock later. During idle it also appears on `dout` as the MSB, and on a downstream unit after its next frame. The bench therefore checks `dout` after every rising edge and checks both chained units at every frame end. A holding register that loads early shows up as `sw_en` moving during shifting, which is checked after every bit. One that loads late or with the wrong data shows up a few `clk` cycles after `sync_n` rises.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  localparam int unsigned SSR_WIDTH_DEF  = 8;
  localparam int unsigned SSR_STAGES_DEF = 2;

  typedef struct packed {
    logic lvl;
    logic rise;
    logic fall;
  } ssr_edge_t;
endpackage

// File: rtl/ssr_rst_sync.sv
module ssr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d[0] = 1'b1;
    for (int i = 1; i < STAGES; i++) chain_d[i] = chain_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_int_n = chain_q[STAGES-1];
endmodule

// File: rtl/ssr_in_sync.sv
module ssr_in_sync
  import ssr_pkg::*;
#(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      raw_in,
  output ssr_edge_t ev
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;
  logic              last_q;
  logic              last_d;

  always_comb begin
    pipe_d[0] = raw_in;
    for (int i = 1; i < STAGES; i++) pipe_d[i] = pipe_q[i-1];
    last_d = pipe_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= {STAGES{RST_VAL}};
      last_q <= RST_VAL;
    end else begin
      pipe_q <= pipe_d;
      last_q <= last_d;
    end
  end

  assign ev.lvl  = pipe_q[STAGES-1];
  assign ev.rise = pipe_q[STAGES-1] & ~last_q;
  assign ev.fall = ~pipe_q[STAGES-1] & last_q;
endmodule

// File: rtl/ssr_shift.sv
module ssr_shift #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             sclk_fall,
  input  logic             sclk_rise,
  input  logic             bit_in,
  output logic [WIDTH-1:0] sreg,
  output logic             chain_out
);
  logic [WIDTH-1:0] sreg_q, sreg_d;
  logic             dout_q, dout_d;
  logic             shift_en;
  logic             tap_en;

  assign shift_en = active & sclk_fall;
  assign tap_en   = ~active | sclk_rise;

  always_comb begin
    sreg_d = sreg_q;
    if (shift_en) sreg_d = {sreg_q[WIDTH-2:0], bit_in};
    dout_d = dout_q;
    if (tap_en) dout_d = sreg_q[WIDTH-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      dout_q <= 1'b0;
    end else begin
      sreg_q <= sreg_d;
      dout_q <= dout_d;
    end
  end

  assign sreg      = sreg_q;
  assign chain_out = dout_q;

  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> $stable(sreg_q)); // R5
  AST_SHIFT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (active && sclk_fall) |=> (sreg_q[WIDTH-1:1] == $past(sreg_q[WIDTH-2:0]))); // R3
  AST_DOUT_IDLE_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (dout_q == $past(sreg_q[WIDTH-1]))); // R9
  AST_DOUT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !sclk_rise) |=> $stable(dout_q)); // R2
endmodule

// File: rtl/ssr_hold.sv
module ssr_hold #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] src,
  output logic [WIDTH-1:0] hold
);
  logic [WIDTH-1:0] hold_q, hold_d;

  always_comb begin
    hold_d = hold_q;
    if (load) hold_d = src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  assign hold = hold_q;

  AST_HOLD_ONLY_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(hold_q)); // R4
endmodule

// File: rtl/serial_switch_reg.sv
module serial_switch_reg
  import ssr_pkg::*;
#(
  parameter int unsigned WIDTH  = SSR_WIDTH_DEF,
  parameter int unsigned STAGES = SSR_STAGES_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_n,
  input  logic             sclk,
  input  logic             din,
  output logic [WIDTH-1:0] sw_en,
  output logic             dout
);
  localparam int unsigned NIN = 3;
  localparam logic [NIN-1:0] IN_RST = 3'b011;

  logic             rst_int_n;
  logic [NIN-1:0]   raw;
  ssr_edge_t        ev [NIN];
  logic [WIDTH-1:0] sreg;
  logic             active;

  assign raw = {din, sclk, sync_n};

  ssr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_int_n(rst_int_n)
  );

  for (genvar g = 0; g < NIN; g++) begin : g_in
    ssr_in_sync #(.STAGES(STAGES), .RST_VAL(IN_RST[g])) u_sync (
      .clk(clk), .rst_n(rst_int_n), .raw_in(raw[g]), .ev(ev[g])
    );
  end

  assign active = ~ev[0].lvl;

  ssr_shift #(.WIDTH(WIDTH)) u_shift (
    .clk(clk), .rst_n(rst_int_n), .active(active),
    .sclk_fall(ev[1].fall), .sclk_rise(ev[1].rise), .bit_in(ev[2].lvl),
    .sreg(sreg), .chain_out(dout)
  );

  ssr_hold #(.WIDTH(WIDTH)) u_hold (
    .clk(clk), .rst_n(rst_int_n), .load(ev[0].rise), .src(sreg), .hold(sw_en)
  );

  AST_FRAME_STABLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    active |=> $stable(sw_en)); // R4
  AST_END_COPIES: assert property (@(posedge clk) disable iff (!rst_int_n)
    ev[0].rise |=> (sw_en == $past(sreg))); // R10
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> (sw_en == '0 && dout == 1'b0)); // R7
endmodule

// File: tb/sim_serial_switch_reg.sv
module sim_serial_switch_reg;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, sync_n, sclk, din;
  logic [7:0] sw0, sw1;
  logic dout0, dout1;

  int total = 0;
  int bad   = 0;
  logic [7:0] m0, m1;
  logic [7:0] e0, e1;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_switch_reg u0 (.clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk),
    .din(din), .sw_en(sw0), .dout(dout0));
  serial_switch_reg u1 (.clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk),
    .din(dout0), .sw_en(sw1), .dout(dout1));

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_bit(logic b);
    din = b;
    wait_clk(2);
    sclk = 1'b0;
    wait_clk(4);
    m1 = {m1[6:0], m0[7]};
    m0 = {m0[6:0], b};
    sclk = 1'b1;
    wait_clk(6);
    check("R2 dout after rise", {7'd0, dout0}, {7'd0, m0[7]});
    check("R4 unit0 stable in frame", sw0, e0);
    check("R4 unit1 stable in frame", sw1, e1);
  endtask

  task automatic frame(logic [15:0] v, int n, string req);
    sync_n = 1'b0;
    wait_clk(4);
    e0 = sw0;
    e1 = sw1;
    for (int i = n - 1; i >= 0; i--) do_bit(v[i]);
    wait_clk(2);
    sync_n = 1'b1;
    wait_clk(8);
    check(req, sw0, m0);
    check("R8 downstream unit", sw1, m1);
    check("R9 idle dout", {7'd0, dout0}, {7'd0, m0[7]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] snap;
    rst_n = 1'b0; sync_n = 1'b1; sclk = 1'b1; din = 1'b0;
    m0 = '0; m1 = '0;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(6);
    check("R7 reset sw0", sw0, 8'h00);
    check("R7 reset sw1", sw1, 8'h00);
    check("R7 reset dout", {7'd0, dout0}, 8'h00);

    // R1: full sweep of 8-bit frames
    for (int v = 0; v < 256; v++) frame(16'(v), 8, "R1 eight-bit frame");

    // R6: mapping and polarity
    frame(16'h0081, 8, "R6 frame 81");
    check("R6 switch1 and switch8 on", sw0, 8'h81);
    frame(16'h0016, 5, "R3 five-bit frame");
    check("R3 five-bit result", sw0, 8'h36);
    frame(16'h05C3, 11, "R3 eleven-bit frame");
    check("R3 eleven-bit result", sw0, 8'hC3);
    for (int v = 0; v < 32; v++) frame(16'(v), 5, "R3 five-bit sweep");
    for (int v = 0; v < 2048; v += 37) frame(16'(v), 11, "R3 eleven-bit sweep");

    // R5: idle noise, then zero-edge frame (R10)
    frame(16'h00A5, 8, "R1 setup");
    snap = m0;
    for (int k = 0; k < 20; k++) begin
      din = k[0];
      wait_clk(2);
      sclk = ~sclk;
      wait_clk(3);
    end
    sclk = 1'b1;
    wait_clk(6);
    check("R5 dout after idle noise", {7'd0, dout0}, {7'd0, snap[7]});
    sync_n = 1'b0;
    wait_clk(6);
    sync_n = 1'b1;
    wait_clk(8);
    check("R10 zero-edge frame sw0", sw0, snap);
    check("R10 zero-edge frame sw1", sw1, m1);
    frame(16'h003C, 8, "R1 after noise");
    check("R5 register untouched by noise", sw1, snap);

    // R7: reset in the middle of a frame
    sync_n = 1'b0;
    wait_clk(4);
    e0 = sw0; e1 = sw1;
    do_bit(1'b1); do_bit(1'b0); do_bit(1'b1);
    rst_n = 1'b0;
    wait_clk(1);
    check("R7 async clear sw0", sw0, 8'h00);
    check("R7 async clear sw1", sw1, 8'h00);
    sync_n = 1'b1; sclk = 1'b1;
    wait_clk(2);
    rst_n = 1'b1;
    m0 = '0; m1 = '0;
    wait_clk(8);
    check("R7 after reset sw0", sw0, 8'h00);
    check("R7 after reset dout", {7'd0, dout0}, 8'h00);
    sync_n = 1'b0;
    wait_clk(6);
    sync_n = 1'b1;
    wait_clk(8);
    check("R7 still zero after empty frame", sw0, 8'h00);
    frame(16'h00F0, 8, "R1 after reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule